// File: doc/BRIEF.md
# Big-Endian Load/Store Address and Lane Steering Unit

This unit sits between the execute stage of a small 32-bit load/store processor and a word-wide data memory. For every memory request it adds a sign-extended 16-bit displacement to a base register value to form a byte address. It presents the word-aligned part of that address to memory and decides which byte lanes take part. With a zero base the displacement acts as an absolute address. With a zero displacement the base acts as a plain pointer.

Stores are steered by replicating the byte or half-word across the data bus and raising write enables only on the addressed lanes. Lane numbering is big-endian: byte 0 of a word occupies bits [31:24]. Loads rely on a memory whose read data appears one clock after the request. The unit keeps the lane offset, size and signedness of each load for that cycle. It then extracts the addressed byte, half-word or word from the returned word and sign- or zero-extends it to 32 bits. A request that breaks the natural alignment of its size, or that uses the reserved size code, is flagged and has no effect on memory.

Top module: `lsu_be_mem_unit`

## Requirements
- R1: The byte address is `base_val` plus `disp` sign-extended to 32 bits, modulo 2^32. `mem_addr` equals that address with bits [1:0] forced to zero.
- R2: A byte store to lane offset k (address bits [1:0] = k) drives `mem_be` bit (3-k) alone. `mem_be` bit n governs `mem_wdata` bits [8n+7:8n], so offset 0 maps to bits [31:24].
- R3: A half-word store at offset 0 drives `mem_be` = 4'b1100. At offset 2 it drives 4'b0011. A word store drives 4'b1111.
- R4: `mem_wdata` holds `store_data[7:0]` in all four lanes for a byte store, `store_data[15:0]` in both halves for a half-word store, and `store_data` unchanged for a word store.
- R5: Sizes are coded 00 byte, 01 half-word, 10 word, and 11 is reserved. A half-word with address bit 0 set, a word with address bits [1:0] non-zero, or the reserved size is misaligned. A misaligned request raises `misalign` in the same cycle and drives `mem_be` = 0, `mem_we` = 0 and `mem_re` = 0.
- R6: A byte load returns the lane chosen by the offset, with byte 0 taken from bits [31:24]. It is sign-extended when `req_signed` is 1 and zero-extended when it is 0.
- R7: A half-word load returns bits [31:16] at offset 0 and bits [15:0] at offset 2. It is sign-extended when `req_signed` is 1 and zero-extended when it is 0.
- R8: A word load returns the memory word unchanged, whatever `req_signed` is.
- R9: `load_valid` is high in the cycle after an aligned load request and only then. Stores, misaligned requests and idle cycles produce no `load_valid`.
- R10: During and right after synchronous reset with no request, `load_valid`, `mem_we`, `mem_re` and `mem_be` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend narrow loads when 1 |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store, right-aligned |
| mem_rdata | input | 32 | Memory read word, one cycle after `mem_re` |
| mem_addr | output | 32 | Word address (bits [1:0] zero) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | 4 | Byte write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-steered store data |
| misalign | output | 1 | Current request is misaligned or has the reserved size |
| load_data | output | 32 | Extended load result |
| load_valid | output | 1 | `load_data` holds the result of the previous cycle's load |

## Verification
The hardest case to reach is a load issued in the cycle right after a store to the same word, with lane state held across a request that is rejected. The stimulus therefore writes known patterns through the unit's own store path one lane at a time and reads every lane back at once, both signed and unsigned. It then places misaligned and reserved-size requests between real loads, so that a stale lane or a spurious `load_valid` would shift the scoreboard queue. Address wrap is reached with large bases and negative displacements that cross zero and the top of the address space.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [ADDR_W-1:0]    base_val,
  input  logic [DISP_W-1:0]    disp,
  input  acc_size_e            size,
  output logic [ADDR_W-1:0]    eff_addr,
  output logic                 aligned,
  output logic [LANE_BITS-1:0] lane_off
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  // displacement widened with its sign before the add
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign eff_addr = base_val + disp_ext;
  assign lane_off = eff_addr[LANE_BITS-1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~eff_addr[0];
      SZ_WORD: aligned = (eff_addr[LANE_BITS-1:0] == '0);
      default: aligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LANES     = DATA_W / 8,
  parameter int LANE_BITS = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  acc_size_e            size,
  input  logic [LANE_BITS-1:0] lane_off,
  input  logic [DATA_W-1:0]    store_data,
  output logic [LANES-1:0]     be,
  output logic [DATA_W-1:0]    wdata
);
  // byte number j (big-endian) lives at bits [DATA_W-1-8j -: 8], enable bit LANES-1-j
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int HI   = DATA_W - 1 - 8 * j;
    localparam int HSEL = 15 - 8 * (j % 2);
    logic sel;

    always_comb begin
      unique case (size)
        SZ_BYTE: sel = (lane_off == LANE_BITS'(j));
        SZ_HALF: sel = (lane_off[LANE_BITS-1:1] == LANE_BITS'(j) >> 1);
        SZ_WORD: sel = 1'b1;
        default: sel = 1'b0;
      endcase
    end

    assign be[LANES-1-j] = wr_en & sel;

    always_comb begin
      unique case (size)
        SZ_BYTE: wdata[HI -: 8] = store_data[7:0];
        SZ_HALF: wdata[HI -: 8] = store_data[HSEL -: 8];
        default: wdata[HI -: 8] = store_data[HI -: 8];
      endcase
    end
  end

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && size == SZ_BYTE) |-> $countones(be) == 1); // R2

  AST_HALF_LANE_PAIR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && size == SZ_HALF) |-> (be == 4'b1100 || be == 4'b0011)); // R3
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LANES     = DATA_W / 8,
  parameter int LANE_BITS = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_en,
  input  acc_size_e            size,
  input  logic [LANE_BITS-1:0] lane_off,
  input  logic                 sgn,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [DATA_W-1:0]    load_data,
  output logic                 load_valid
);
  logic                 v_q;
  acc_size_e            size_q;
  logic [LANE_BITS-1:0] off_q;
  logic                 sgn_q;

  // lane context held for the cycle in which memory returns the word
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      size_q <= SZ_BYTE;
      off_q  <= '0;
      sgn_q  <= 1'b0;
    end else begin
      v_q <= cap_en;
      if (cap_en) begin
        size_q <= size;
        off_q  <= lane_off;
        sgn_q  <= sgn;
      end
    end
  end

  logic [DATA_W-1:0] sh_b, sh_h;
  logic [7:0]        b_v;
  logic [15:0]       h_v;

  always_comb begin
    sh_b = mem_rdata >> (8 * (LANES - 1 - int'(off_q)));
    sh_h = mem_rdata >> (8 * (LANES - 2 - int'({off_q[LANE_BITS-1:1], 1'b0})));
    b_v  = sh_b[7:0];
    h_v  = sh_h[15:0];
    load_data = '0;
    if (v_q) begin
      unique case (size_q)
        SZ_BYTE: load_data = {{(DATA_W-8){sgn_q & b_v[7]}}, b_v};
        SZ_HALF: load_data = {{(DATA_W-16){sgn_q & h_v[15]}}, h_v};
        default: load_data = mem_rdata;
      endcase
    end
  end

  assign load_valid = v_q;
endmodule

// File: rtl/lsu_be_mem_unit.sv
module lsu_be_mem_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] store_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              misalign,
  output logic [DATA_W-1:0] load_data,
  output logic              load_valid
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  acc_size_e            size;
  logic [ADDR_W-1:0]    eff_addr;
  logic                 aligned;
  logic [LANE_BITS-1:0] lane_off;

  assign size = acc_size_e'(req_size);

  lsu_addr_gen #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .LANE_BITS(LANE_BITS)
  ) u_agen (
    .base_val(base_val), .disp(disp), .size(size),
    .eff_addr(eff_addr), .aligned(aligned), .lane_off(lane_off)
  );

  assign mem_addr = {eff_addr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
  assign misalign = req_valid & ~aligned;
  assign mem_we   = req_valid & req_store & aligned;
  assign mem_re   = req_valid & ~req_store & aligned;

  lsu_store_lane #(
    .DATA_W(DATA_W), .LANES(LANES), .LANE_BITS(LANE_BITS)
  ) u_st (
    .clk(clk), .rst(rst), .wr_en(mem_we), .size(size), .lane_off(lane_off),
    .store_data(store_data), .be(mem_be), .wdata(mem_wdata)
  );

  lsu_load_align #(
    .DATA_W(DATA_W), .LANES(LANES), .LANE_BITS(LANE_BITS)
  ) u_ld (
    .clk(clk), .rst(rst), .cap_en(mem_re), .size(size), .lane_off(lane_off),
    .sgn(req_signed), .mem_rdata(mem_rdata),
    .load_data(load_data), .load_valid(load_valid)
  );

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (mem_be == '0 && !mem_we && !mem_re)); // R5

  AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> load_valid); // R9

  AST_NO_LOAD_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
    !mem_re |=> !load_valid); // R9
endmodule

// File: tb/tb_lsu_be_mem_unit.sv
module tb_lsu_be_mem_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base_val = '0, store_data = '0;
  logic [15:0] disp = '0;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic        mem_we, mem_re, misalign, load_valid;
  logic [3:0]  mem_be;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mem [16];
  logic [31:0] rd_q = '0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_be_mem_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .base_val(base_val),
    .disp(disp), .store_data(store_data), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .misalign(misalign), .load_data(load_data),
    .load_valid(load_valid)
  );

  // memory model: enable bit n writes data bits [8n+7:8n], read registered
  always @(posedge clk) begin
    if (mem_we)
      for (int n = 0; n < 4; n++)
        if (mem_be[n]) mem[mem_addr[5:2]][8*n +: 8] <= mem_wdata[8*n +: 8];
    if (mem_re) rd_q <= mem[mem_addr[5:2]];
  end
  assign mem_rdata = rd_q;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] sz,
                                       input logic [1:0] off, input logic sg);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[31 - 8*off -: 8];
    h = off[1] ? w[15:0] : w[31:16];
    case (sz)
      2'b00:   return sg ? {{24{b[7]}}, b} : {24'h0, b};
      2'b01:   return sg ? {{16{h[15]}}, h} : {16'h0, h};
      default: return w;
    endcase
  endfunction

  // driver: issue one request, check the same-cycle outputs, queue load results
  task automatic issue(input logic st, input logic [1:0] sz, input logic sg,
                       input logic [31:0] b, input logic [15:0] d,
                       input logic [31:0] sd, input string tag);
    logic [31:0] ea, ew, xd;
    logic [3:0]  xb;
    logic        ok;
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = sz; req_signed = sg;
    base_val = b; disp = d; store_data = sd;
    #1;
    ea = b + {{16{d[15]}}, d};
    ok = (sz == 2'b00) || (sz == 2'b01 && !ea[0]) || (sz == 2'b10 && ea[1:0] == 2'b00);
    check({tag, " misalign"}, {31'h0, misalign}, {31'h0, !ok});
    if (!ok) begin
      check({tag, " R5 quiet"}, {26'h0, mem_be, mem_we, mem_re}, 32'h0);
    end else begin
      check({tag, " R1 addr"}, mem_addr, {ea[31:2], 2'b00});
      check({tag, " strobes"}, {30'h0, mem_we, mem_re}, {30'h0, st, !st});
      if (st) begin
        case (sz)
          2'b00:   begin xb = 4'b1000 >> ea[1:0]; xd = {4{sd[7:0]}}; end
          2'b01:   begin xb = ea[1] ? 4'b0011 : 4'b1100; xd = {2{sd[15:0]}}; end
          default: begin xb = 4'b1111; xd = sd; end
        endcase
        check({tag, " R2/R3 be"}, {28'h0, mem_be}, {28'h0, xb});
        check({tag, " R4 wdata"}, mem_wdata, xd);
      end else begin
        ew = pick(mem[ea[5:2]], sz, ea[1:0], sg);
        exp_q.push_back(ew);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_store = 0;
  endtask

  // monitor: every load_valid must match the oldest queued expectation (R9)
  always @(posedge clk) begin
    #2;
    if (!rst && load_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 spurious load_valid: actual 1 expected 0");
      end else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " load_data"}, load_data, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h80F17F09 + i * 32'h01030507;
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset", {28'h0, load_valid, mem_we, mem_re, misalign}, 32'h0);
    check("R10 reset be", {28'h0, mem_be}, 32'h0);
    @(negedge clk); rst = 0;
    #1;
    check("R10 after reset", {29'h0, load_valid, mem_we, mem_re}, 32'h0);

    // R4 R3 word store through a pointer (zero displacement)
    issue(1, 2'b10, 0, 32'h20, 16'h0000, 32'hA1B2C3D4, "R3 word store");
    // R2 one byte per lane, negative displacement
    for (int k = 0; k < 4; k++)
      issue(1, 2'b00, 0, 32'h30, 16'(-12 + k), 32'h1234_5600 | 32'(8'h7E + 8'(k * 3)), "R2 byte store");
    // R3 half stores at offsets 0 and 2
    issue(1, 2'b01, 0, 32'h28, 16'h0000, 32'hDEAD8001, "R3 half store hi");
    issue(1, 2'b01, 0, 32'h28, 16'h0002, 32'hBEEF7FFE, "R3 half store lo");
    // load right after store to the same word
    issue(1, 2'b10, 0, 32'h2C, 16'h0000, 32'hF00F55AA, "R4 word store");
    issue(0, 2'b10, 1, 32'h2C, 16'h0000, 32'h0, "R8 word load back-to-back");

    // R6 every lane signed and unsigned
    for (int k = 0; k < 4; k++) begin
      issue(0, 2'b00, 1, 32'h24, 16'(k), 32'h0, "R6 byte signed");
      issue(0, 2'b00, 0, 32'h24, 16'(k), 32'h0, "R6 byte unsigned");
    end
    // R7 half loads
    for (int k = 0; k < 2; k++) begin
      issue(0, 2'b01, 1, 32'h28, 16'(2 * k), 32'h0, "R7 half signed");
      issue(0, 2'b01, 0, 32'h28, 16'(2 * k), 32'h0, "R7 half unsigned");
    end
    issue(0, 2'b01, 1, 32'h00, 16'h0004, 32'h0, "R7 half init word");
    issue(0, 2'b10, 0, 32'h20, 16'h0000, 32'h0, "R8 word unsigned");

    // R5 misaligned and reserved, mixed between loads
    issue(0, 2'b01, 1, 32'h24, 16'h0001, 32'h0, "R5 half odd load");
    issue(0, 2'b00, 1, 32'h08, 16'h0003, 32'h0, "R6 byte after reject");
    issue(1, 2'b10, 0, 32'h20, 16'h0002, 32'hFFFFFFFF, "R5 word store off2");
    issue(0, 2'b10, 0, 32'h21, 16'h0000, 32'h0, "R5 word load off1");
    issue(1, 2'b11, 0, 32'h20, 16'h0000, 32'h0, "R5 reserved store");
    issue(0, 2'b11, 0, 32'h20, 16'h0000, 32'h0, "R5 reserved load");
    issue(0, 2'b10, 0, 32'h20, 16'h0000, 32'h0, "R8 word after rejects");

    // R1 absolute addressing and wrap
    issue(0, 2'b10, 0, 32'h0, 16'h7FF0, 32'h0, "R1 absolute");
    issue(0, 2'b10, 0, 32'h10000000, 16'hFFFC, 32'h0, "R1 negative disp");
    issue(0, 2'b00, 1, 32'h00000010, 16'hFFF0, 32'h0, "R1 to zero");
    issue(0, 2'b10, 0, 32'hFFFFFFF8, 16'h0010, 32'h0, "R1 wrap top");

    idle();
    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing load_valid: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule